// File: doc/BRIEF.md
# Peripheral Slot Select Decoder

This block sits between an 8-bit processor bus and a seven-slot expansion backplane. It watches the 16-bit address during the second half of each bus cycle, while phase 0 is high. For each slot it drives an active-low strobe when the processor touches that slot's 256-byte firmware page. It drives a second active-low strobe when the processor touches that slot's 16-byte register window. All slots share one active-low strobe for the 2 KiB expansion-ROM window. The block also produces the enable and write qualifier for the on-board memory, which a card can suppress for a cycle by pulling the inhibit line low during phase 1.

The block also forms the interrupt and DMA priority daisy chains. Each chain carries a grant from a head input through slots 1 to 7 in order. A slot that is requesting keeps the grant, so no later slot receives it. The inhibit input is captured on the system clock while phase 1 is high. The value from the last clock of phase 1 stays in force for all of the following phase 0. Everything else is combinational from the bus inputs.

Top module: `slot_select_decoder`

## Requirements
- R1: While phi0 is low, every io_sel_n and dev_sel_n bit and io_strobe_n are high, and mem_en and mem_wr are low.
- R2: While phi0 is high, io_sel_n bit k (slot k+1, k = 0..6) is low exactly when the address lies in 0xC(k+1)00 to 0xC(k+1)FF.
- R3: No io_sel_n bit is ever low for an address in page 0xC0, and at most one io_sel_n bit is low at a time.
- R4: While phi0 is high, dev_sel_n bit k (slot k+1) is low exactly when the address lies in 0xC0m0 to 0xC0mF with m = k+9, so 0xC080 to 0xC08F selects no slot.
- R5: While phi0 is high, io_strobe_n is low exactly for addresses 0xC800 to 0xCFFF.
- R6: While phi0 is high and the held inhibit state is inactive, mem_en is high exactly for addresses outside 0xC000 to 0xCFFF; it is never high inside that range.
- R7: The inhibit state is taken from inh_n on each clock edge where phi1 is high and held on every other edge. A low sample forces mem_en low for the following phase 0, and changes of inh_n while phi1 is low have no effect.
- R8: mem_wr is high exactly when mem_en is high and rw is low (rw high means read).
- R9: For each chain, the grant into slot 1 is the head input and the grant into slot n+1 is the chain-out of slot n. Chain-out bit k equals its grant-in AND NOT the request bit k. The interrupt and DMA chains are independent.
- R10: After reset the held inhibit state is inactive, so mem_en follows R6 before any phase 1 has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the inhibit line |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 16 | Processor address bus |
| rw | input | 1 | High for read, low for write |
| phi0 | input | 1 | Phase-0 clock level |
| phi1 | input | 1 | Phase-1 clock level |
| inh_n | input | 1 | Active-low on-board memory inhibit from the cards |
| int_req | input | 7 | Interrupt requests, bit k from slot k+1 |
| dma_req | input | 7 | DMA requests, bit k from slot k+1 |
| int_head | input | 1 | Interrupt grant entering slot 1 |
| dma_head | input | 1 | DMA grant entering slot 1 |
| io_sel_n | output | 7 | Per-slot firmware-page selects, bit k for slot k+1 |
| dev_sel_n | output | 7 | Per-slot register-window selects, bit k for slot k+1 |
| io_strobe_n | output | 1 | Shared expansion-ROM strobe |
| mem_en | output | 1 | On-board memory enable |
| mem_wr | output | 1 | On-board memory write qualifier |
| int_chain_out | output | 7 | Interrupt chain-out per slot |
| dma_chain_out | output | 7 | DMA chain-out per slot |

## Verification
The decoder is swept over all 65,536 addresses with phi0 high and rw toggling, and then over the I/O page with phi0 low. The high sweep separates a wrong page or nibble offset, an off-by-one at a window boundary, and a leak of the select into page 0xC0 or 0xC080. The low sweep catches a missing phase gate. Both chains are run through all 128 request patterns with the head input at each value. The DMA chain gets a different pattern from the interrupt chain, so that crossed wiring shows. The inhibit path is driven with inh_n changes inside and outside phase 1, which separates sampling at the wrong time from failing to hold.

// File: rtl/slot_sel_pkg.sv
package slot_sel_pkg;

  localparam int unsigned BUS_ADDR_W = 16;

  // Whole I/O region; the on-board memory is never enabled inside it.
  localparam logic [BUS_ADDR_W-1:0] IO_REGION_LO = 16'hC000;
  localparam logic [BUS_ADDR_W-1:0] IO_REGION_HI = 16'hCFFF;

  // Shared expansion-ROM window.
  localparam logic [BUS_ADDR_W-1:0] XROM_LO = 16'hC800;
  localparam logic [BUS_ADDR_W-1:0] XROM_HI = 16'hCFFF;

  // Register windows are numbered from slot index plus this offset.
  localparam int unsigned REG_WIN_OFFSET = 8;
  localparam int unsigned PAGE_SHIFT     = 8;
  localparam int unsigned WIN_SHIFT      = 4;

  function automatic logic [BUS_ADDR_W-1:0] page_lo(input int unsigned slot);
    return IO_REGION_LO + BUS_ADDR_W'(slot << PAGE_SHIFT);
  endfunction

  function automatic logic [BUS_ADDR_W-1:0] page_hi(input int unsigned slot);
    return page_lo(slot) + BUS_ADDR_W'((1 << PAGE_SHIFT) - 1);
  endfunction

  function automatic logic [BUS_ADDR_W-1:0] win_lo(input int unsigned slot);
    return IO_REGION_LO + BUS_ADDR_W'((slot + REG_WIN_OFFSET) << WIN_SHIFT);
  endfunction

  function automatic logic [BUS_ADDR_W-1:0] win_hi(input int unsigned slot);
    return win_lo(slot) + BUS_ADDR_W'((1 << WIN_SHIFT) - 1);
  endfunction

endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/slot_addr_decode.sv
module slot_addr_decode
  import slot_sel_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 7,
  parameter int unsigned ADDR_W    = BUS_ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 phi0,
  output logic [NUM_SLOTS-1:0] io_sel_n,
  output logic [NUM_SLOTS-1:0] dev_sel_n,
  output logic                 io_strobe_n,
  output logic                 in_io_region
);

  logic [NUM_SLOTS-1:0] page_hit;
  logic [NUM_SLOTS-1:0] win_hit;
  logic                 xrom_hit;

  // One comparator pair per slot for each window kind.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int unsigned       SLOT_IDX = s + 1;
    localparam logic [ADDR_W-1:0] P_LO = ADDR_W'(page_lo(SLOT_IDX));
    localparam logic [ADDR_W-1:0] P_HI = ADDR_W'(page_hi(SLOT_IDX));
    localparam logic [ADDR_W-1:0] W_LO = ADDR_W'(win_lo(SLOT_IDX));
    localparam logic [ADDR_W-1:0] W_HI = ADDR_W'(win_hi(SLOT_IDX));

    assign page_hit[s] = (addr >= P_LO) && (addr <= P_HI);
    assign win_hit[s]  = (addr >= W_LO) && (addr <= W_HI);
  end

  assign xrom_hit     = (addr >= ADDR_W'(XROM_LO)) && (addr <= ADDR_W'(XROM_HI));
  assign in_io_region = (addr >= ADDR_W'(IO_REGION_LO)) && (addr <= ADDR_W'(IO_REGION_HI));

  // Phase-0 gating of every select.
  always_comb begin
    io_sel_n    = ~(page_hit & {NUM_SLOTS{phi0}});
    dev_sel_n   = ~(win_hit  & {NUM_SLOTS{phi0}});
    io_strobe_n = ~(xrom_hit & phi0);
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !phi0 |-> (&io_sel_n) && (&dev_sel_n) && io_strobe_n);

  p_page_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~io_sel_n));

  p_page_c0_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:8] == 8'hC0) |-> (&io_sel_n));

  p_win_vs_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(&dev_sel_n) |-> (&io_sel_n) && $onehot0(~dev_sel_n));

  p_xrom_in_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !io_strobe_n |-> in_io_region && (&io_sel_n));

endmodule

// File: rtl/board_mem_gate.sv
module board_mem_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic phi0,
  input  logic phi1,
  input  logic inh_n,
  input  logic rw,
  input  logic in_io_region,
  output logic mem_en,
  output logic mem_wr
);

  logic inh_keep_q;
  logic inh_keep_d;
  logic sample_en;

  // Clock enable: follow the line only during phase 1.
  assign sample_en = phi1;

  always_comb begin
    inh_keep_d = inh_keep_q;
    if (sample_en) begin
      inh_keep_d = inh_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_keep_q <= 1'b1;
    end else begin
      inh_keep_q <= inh_keep_d;
    end
  end

  always_comb begin
    mem_en = phi0 && !in_io_region && inh_keep_q;
    mem_wr = mem_en && !rw;
  end

  p_mem_outside_io_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !in_io_region && phi0);

  p_inhibit_applies_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phi1) && !$past(inh_n) && !phi1) |-> !mem_en);

  p_hold_outside_p1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !phi1 |=> $stable(inh_keep_q));

  p_write_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_en && !rw);

endmodule

// File: rtl/priority_chain.sv
module priority_chain #(
  parameter int unsigned NUM_SLOTS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 head,
  input  logic [NUM_SLOTS-1:0] req,
  output logic [NUM_SLOTS-1:0] chain_out
);

  logic [NUM_SLOTS-1:0] chain_in;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_link
    if (s == 0) begin : g_first
      assign chain_in[s] = head;
    end else begin : g_next
      assign chain_in[s] = chain_out[s-1];
    end
    assign chain_out[s] = chain_in[s] & ~req[s];
  end

  p_request_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req & chain_out) == '0);

  p_head_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !head |-> (chain_out == '0));

  p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req & chain_in));

endmodule

// File: rtl/slot_select_decoder.sv
module slot_select_decoder
  import slot_sel_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 7,
  parameter int unsigned ADDR_W    = BUS_ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rw,
  input  logic                 phi0,
  input  logic                 phi1,
  input  logic                 inh_n,
  input  logic [NUM_SLOTS-1:0] int_req,
  input  logic [NUM_SLOTS-1:0] dma_req,
  input  logic                 int_head,
  input  logic                 dma_head,
  output logic [NUM_SLOTS-1:0] io_sel_n,
  output logic [NUM_SLOTS-1:0] dev_sel_n,
  output logic                 io_strobe_n,
  output logic                 mem_en,
  output logic                 mem_wr,
  output logic [NUM_SLOTS-1:0] int_chain_out,
  output logic [NUM_SLOTS-1:0] dma_chain_out
);

  logic srst_n;
  logic in_io_region;

  rst_release_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  slot_addr_decode #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_dec (
    .clk          (clk),
    .rst_n        (srst_n),
    .addr         (addr),
    .phi0         (phi0),
    .io_sel_n     (io_sel_n),
    .dev_sel_n    (dev_sel_n),
    .io_strobe_n  (io_strobe_n),
    .in_io_region (in_io_region)
  );

  board_mem_gate u_mem (
    .clk          (clk),
    .rst_n        (srst_n),
    .phi0         (phi0),
    .phi1         (phi1),
    .inh_n        (inh_n),
    .rw           (rw),
    .in_io_region (in_io_region),
    .mem_en       (mem_en),
    .mem_wr       (mem_wr)
  );

  priority_chain #(.NUM_SLOTS(NUM_SLOTS)) u_int_chain (
    .clk       (clk),
    .rst_n     (srst_n),
    .head      (int_head),
    .req       (int_req),
    .chain_out (int_chain_out)
  );

  priority_chain #(.NUM_SLOTS(NUM_SLOTS)) u_dma_chain (
    .clk       (clk),
    .rst_n     (srst_n),
    .head      (dma_head),
    .req       (dma_req),
    .chain_out (dma_chain_out)
  );

endmodule

// File: tb/slot_select_decoder_tb.sv
module slot_select_decoder_tb;

  localparam int NS = 7;

  logic          clk;
  logic          rst_n;
  logic [15:0]   addr;
  logic          rw, phi0, phi1, inh_n;
  logic [NS-1:0] int_req, dma_req;
  logic          int_head, dma_head;
  logic [NS-1:0] io_sel_n, dev_sel_n;
  logic          io_strobe_n, mem_en, mem_wr;
  logic [NS-1:0] int_chain_out, dma_chain_out;

  int n_cmp;
  int n_bad;
  int cycles;
  bit done;

  slot_select_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .phi0(phi0), .phi1(phi1),
    .inh_n(inh_n), .int_req(int_req), .dma_req(dma_req), .int_head(int_head),
    .dma_head(dma_head), .io_sel_n(io_sel_n), .dev_sel_n(dev_sel_n),
    .io_strobe_n(io_strobe_n), .mem_en(mem_en), .mem_wr(mem_wr),
    .int_chain_out(int_chain_out), .dma_chain_out(dma_chain_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected bus-side outputs, from the requirements.
  function automatic logic [17:0] expect_bus(input logic [15:0] a, input logic p0,
                                             input logic r, input logic inh_ok);
    logic [NS-1:0] e_io, e_dev;
    logic e_xs, e_me, e_wr;
    for (int k = 0; k < NS; k++) begin
      e_io[k]  = !(p0 && a[15:8] == 8'(8'hC0 + k + 1));
      e_dev[k] = !(p0 && a[15:4] == 12'(12'hC00 + k + 9));
    end
    e_xs = !(p0 && a >= 16'hC800 && a <= 16'hCFFF);
    e_me = p0 && (a < 16'hC000 || a > 16'hCFFF) && inh_ok;
    e_wr = e_me && !r;
    return {e_io, e_dev, e_xs, e_me, e_wr, 1'b0};
  endfunction

  function automatic logic [NS-1:0] expect_chain(input logic h, input logic [NS-1:0] rq);
    logic g;
    logic [NS-1:0] o;
    g = h;
    for (int k = 0; k < NS; k++) begin
      o[k] = g & ~rq[k];
      g    = o[k];
    end
    return o;
  endfunction

  function automatic logic [17:0] got_bus();
    return {io_sel_n, dev_sel_n, io_strobe_n, mem_en, mem_wr, 1'b0};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0; addr = 16'h1234; rw = 1'b1; phi0 = 1'b0; phi1 = 1'b0;
    inh_n = 1'b0; int_req = '0; dma_req = '0; int_head = 1'b0; dma_head = 1'b0;
    repeat (3) step();
    #2;
    check("R1 reset idle", 32'(got_bus()), 32'(expect_bus(addr, 1'b0, rw, 1'b1)));
    step(); rst_n = 1'b1;
    repeat (3) step();
    // R10: no phase 1 yet, inhibit state inactive even with inh_n low.
    phi0 = 1'b1; addr = 16'h0400;
    #2;
    check("R10 post-reset mem_en", 32'(mem_en), 32'd1);

    // Sweep all addresses with phi0 high, inhibit inactive.
    step(); phi0 = 1'b0; phi1 = 1'b1; inh_n = 1'b1;
    step(); phi1 = 1'b0; phi0 = 1'b1;
    for (int a = 0; a < 65536; a++) begin
      step();
      addr = 16'(a);
      rw   = addr[0] ^ addr[5];
      #2;
      check("R2 R3 R4 R5 R6 R8 sweep", 32'(got_bus()),
            32'(expect_bus(addr, 1'b1, rw, 1'b1)));
    end

    // Phase 0 low across the I/O region and a memory address.
    phi0 = 1'b0;
    for (int a = 16'hC000; a <= 16'hD000; a++) begin
      step();
      addr = 16'(a);
      rw   = 1'b0;
      #2;
      check("R1 idle sweep", 32'(got_bus()), 32'(expect_bus(addr, 1'b0, rw, 1'b1)));
    end

    // R7: inhibit sampled low in phase 1, line released in phase 0.
    step(); phi0 = 1'b0; phi1 = 1'b1; inh_n = 1'b0; addr = 16'h2000; rw = 1'b0;
    step(); phi1 = 1'b0; phi0 = 1'b1; inh_n = 1'b1;
    #2;
    check("R7 inhibited", 32'({mem_en, mem_wr}), 32'd0);
    step(); step();
    #2;
    check("R7 inhibit held", 32'({mem_en, mem_wr}), 32'd0);
    // Line pulled low only during phase 0: ignored.
    step(); phi0 = 1'b0; phi1 = 1'b1; inh_n = 1'b1;
    step(); phi1 = 1'b0; phi0 = 1'b1;
    #2;
    check("R7 released", 32'({mem_en, mem_wr}), 32'b11);
    step(); inh_n = 1'b0;
    step();
    #2;
    check("R7 phase0 change ignored", 32'({mem_en, mem_wr}), 32'b11);
    rw = 1'b1;
    #1;
    check("R8 read", 32'({mem_en, mem_wr}), 32'b10);
    // Inhibit low early in phase 1 but high on its last clock.
    step(); phi0 = 1'b0; phi1 = 1'b1; inh_n = 1'b0;
    step(); inh_n = 1'b1;
    step(); phi1 = 1'b0; phi0 = 1'b1;
    #2;
    check("R7 last sample wins", 32'(mem_en), 32'd1);

    // Priority chains: all request patterns, both head values.
    for (int h = 0; h < 2; h++) begin
      for (int p = 0; p < 128; p++) begin
        step();
        int_head = h[0];
        dma_head = ~h[0];
        int_req  = NS'(p);
        dma_req  = NS'(p) ^ 7'h55;
        #2;
        check("R9 int chain", 32'(int_chain_out), 32'(expect_chain(int_head, int_req)));
        check("R9 dma chain", 32'(dma_chain_out), 32'(expect_chain(dma_head, dma_req)));
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule